// File: doc/BRIEF.md
# Beam-Position Display Interrupt Unit

This block raises the processor's display interrupt when the video beam reaches chosen lines. It holds four independent compare channels. Each channel stores a target line number, a horizontal compare value, an enable (mask) bit and a pending bit. Whenever the beam line counter advances, every channel whose target equals the new line sets its pending bit. A single interrupt line to the processor is the OR, over all channels, of pending AND mask. This line is registered.

Software programs a channel through 16-bit writes to its upper or lower half. The upper half carries the target line, the mask and the pending bit, so writing it with the pending bit low acknowledges the interrupt. A clear strobe from the display control logic wipes all four channels at once. A combinational read port returns either half of any channel. After reset, channels 0 and 1 hold their preset timing values and channels 2 and 3 are empty.

Top module: `beam_irq_unit`

## Requirements
- R1: After reset, channel 0 reads upper 0x1107 (target 263, mask 1, pending 0) and lower 430. Channel 1 reads upper 0x1001 and lower 1. Channels 2 and 3 read zero in both halves, and irqOut is 0.
- R2: On a cycle with beamAdv high, each channel whose target line equals beamLine sets its pending bit. Other channels keep their pending bits.
- R3: irqOut is registered. It equals the OR over channels of (pending AND mask) as held one clock earlier.
- R4: A pending channel whose mask is 0 does not drive irqOut, and clearing a mask drops irqOut.
- R5: An upper-half write (wrHigh=1) replaces the channel's fields from wrData: target line in bits [9:0], mask in bit 12, pending in bit 15. The other bits read back as 0. Writing pending as 0 acknowledges the interrupt.
- R6: A lower-half write (wrHigh=0) replaces only the horizontal compare in bits [9:0] and leaves the upper half unchanged.
- R7: clearAll zeroes every field of all four channels. It takes priority over writes and line matches in the same cycle.
- R8: If an upper-half write and a line match hit the same channel in the same cycle, the written pending value wins.
- R9: With beamAdv low, a beamLine equal to a target sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, loads preset values |
| beamAdv | input | 1 | Beam line counter advanced this cycle |
| beamLine | input | 10 | New beam line value |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Channel addressed by write |
| wrHigh | input | 1 | 1 selects upper half, 0 lower half |
| wrData | input | 16 | Write data |
| clearAll | input | 1 | Clear all channels |
| rdSel | input | 2 | Channel addressed by read |
| rdHigh | input | 1 | 1 reads upper half, 0 lower half |
| rdData | output | 16 | Read data |
| irqOut | output | 1 | Processor display interrupt |

## Verification
The bench builds the block with its default parameters: four channels, a 10-bit line field, and presets of 263/430 and 1/1. These values let the bench check the reset presets and the real top target line of 263 directly. Every channel can also be loaded with small target lines, so a short beam sequence reaches all four compare paths, both masked and unmasked. The same-cycle collisions of clear, write and match are driven deliberately.

// File: rtl/beam_irq_pkg.sv
package beam_irq_pkg;
  localparam int CH_COUNT = 4;
  localparam int SEL_WIDTH = $clog2(CH_COUNT);
  localparam int WORD_W = 16;
  localparam int MASK_BIT = 12;
  localparam int PEND_BIT = 15;

  typedef struct packed {
    logic [CH_COUNT-1:0] hiStb;
    logic [CH_COUNT-1:0] loStb;
    logic                clr;
  } chan_strobe_t;
endpackage

// File: rtl/beam_irq_ctrl.sv
module beam_irq_ctrl
  import beam_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SEL_WIDTH-1:0] wrSel,
  input  logic                 wrHigh,
  input  logic                 clearAll,
  output chan_strobe_t         stb
);
  always_comb begin
    stb = '0;
    stb.clr = clearAll;
    for (int i = 0; i < CH_COUNT; i++) begin
      if (wrEn && (wrSel == SEL_WIDTH'(i))) begin
        if (wrHigh) stb.hiStb[i] = 1'b1;
        else        stb.loStb[i] = 1'b1;
      end
    end
  end

  // R5 R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.hiStb, stb.loStb}));

  // R5
  hi_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.hiStb) |-> (wrEn && wrHigh));
endmodule

// File: rtl/beam_irq_datapath.sv
module beam_irq_datapath
  import beam_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PRE0_V = 263,
  parameter int PRE0_H = 430,
  parameter int PRE1_V = 1,
  parameter int PRE1_H = 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  chan_strobe_t         stb,
  input  logic                 beamAdv,
  input  logic [LINE_W-1:0]    beamLine,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [SEL_WIDTH-1:0] rdSel,
  input  logic                 rdHigh,
  output logic [WORD_W-1:0]    rdData,
  output logic                 irqOut
);
  logic [LINE_W-1:0] vCmp [CH_COUNT];
  logic [LINE_W-1:0] hCmp [CH_COUNT];
  logic [CH_COUNT-1:0] maskVec;
  logic [CH_COUNT-1:0] pendVec;

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
    localparam logic [LINE_W-1:0] RST_V =
      (i == 0) ? LINE_W'(PRE0_V) : (i == 1) ? LINE_W'(PRE1_V) : '0;
    localparam logic [LINE_W-1:0] RST_H =
      (i == 0) ? LINE_W'(PRE0_H) : (i == 1) ? LINE_W'(PRE1_H) : '0;
    localparam logic RST_M = (i < 2);

    logic lineHit;
    assign lineHit = beamAdv && (beamLine == vCmp[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vCmp[i]    <= RST_V;
        hCmp[i]    <= RST_H;
        maskVec[i] <= RST_M;
        pendVec[i] <= 1'b0;
      end else if (stb.clr) begin
        vCmp[i]    <= '0;
        hCmp[i]    <= '0;
        maskVec[i] <= 1'b0;
        pendVec[i] <= 1'b0;
      end else if (stb.hiStb[i]) begin
        vCmp[i]    <= wrData[LINE_W-1:0];
        maskVec[i] <= wrData[MASK_BIT];
        pendVec[i] <= wrData[PEND_BIT];
      end else begin
        if (stb.loStb[i]) hCmp[i] <= wrData[LINE_W-1:0];
        if (lineHit) pendVec[i] <= 1'b1;
      end
    end

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.hiStb[i] && !stb.clr) |=> (pendVec[i] == $past(wrData[PEND_BIT])));

    // R2
    match_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (lineHit && !stb.hiStb[i] && !stb.clr) |=> pendVec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(pendVec & maskVec);
  end

  always_comb begin
    rdData = '0;
    if (rdHigh) begin
      rdData[LINE_W-1:0] = vCmp[rdSel];
      rdData[MASK_BIT]   = maskVec[rdSel];
      rdData[PEND_BIT]   = pendVec[rdSel];
    end else begin
      rdData[LINE_W-1:0] = hCmp[rdSel];
    end
  end

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (pendVec == '0 && maskVec == '0));

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|(pendVec & maskVec)));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & maskVec) == '0) |=> !irqOut);
endmodule

// File: rtl/beam_irq_unit.sv
module beam_irq_unit
  import beam_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PRE0_V = 263,
  parameter int PRE0_H = 430,
  parameter int PRE1_V = 1,
  parameter int PRE1_H = 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 beamAdv,
  input  logic [LINE_W-1:0]    beamLine,
  input  logic                 wrEn,
  input  logic [SEL_WIDTH-1:0] wrSel,
  input  logic                 wrHigh,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 clearAll,
  input  logic [SEL_WIDTH-1:0] rdSel,
  input  logic                 rdHigh,
  output logic [WORD_W-1:0]    rdData,
  output logic                 irqOut
);
  chan_strobe_t stb;

  beam_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrHigh(wrHigh), .clearAll(clearAll), .stb(stb)
  );

  beam_irq_datapath #(
    .LINE_W(LINE_W), .PRE0_V(PRE0_V), .PRE0_H(PRE0_H),
    .PRE1_V(PRE1_V), .PRE1_H(PRE1_H)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .beamAdv(beamAdv),
    .beamLine(beamLine), .wrData(wrData), .rdSel(rdSel),
    .rdHigh(rdHigh), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/beam_irq_unit_bench.sv
module beam_irq_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic beamAdv = 1'b0;
  logic [9:0] beamLine = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic wrHigh = 1'b0;
  logic [15:0] wrData = '0;
  logic clearAll = 1'b0;
  logic [1:0] rdSel = '0;
  logic rdHigh = 1'b0;
  logic [15:0] rdData;
  logic irqOut;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  beam_irq_unit u_beam_irq_unit (
    .clk(clk), .rstN(rstN), .beamAdv(beamAdv), .beamLine(beamLine),
    .wrEn(wrEn), .wrSel(wrSel), .wrHigh(wrHigh), .wrData(wrData),
    .clearAll(clearAll), .rdSel(rdSel), .rdHigh(rdHigh),
    .rdData(rdData), .irqOut(irqOut)
  );

  // {line[9:0], expected pending ch3..ch0, expected irq}
  localparam logic [14:0] VEC [5] = '{
    {10'd3,   4'b0000, 1'b0},
    {10'd5,   4'b0100, 1'b0},
    {10'd1,   4'b0110, 1'b1},
    {10'd7,   4'b1110, 1'b1},
    {10'd263, 4'b1111, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] ch, input logic hi, output logic [15:0] val);
    rdSel = ch; rdHigh = hi;
    #1 val = rdData;
  endtask

  task automatic pend(output logic [3:0] p);
    logic [15:0] v;
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 1'b1, v);
      p[c] = v[15];
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic hi, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = ch; wrHigh = hi; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic adv(input logic [9:0] line);
    @(negedge clk);
    beamAdv = 1'b1; beamLine = line;
    @(negedge clk);
    beamAdv = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    logic [3:0] p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset presets
    rd(2'd0, 1'b1, v); chk("R1 ch0 hi", v, 16'h1107);
    rd(2'd0, 1'b0, v); chk("R1 ch0 lo", v, 16'd430);
    rd(2'd1, 1'b1, v); chk("R1 ch1 hi", v, 16'h1001);
    rd(2'd1, 1'b0, v); chk("R1 ch1 lo", v, 16'd1);
    rd(2'd2, 1'b1, v); chk("R1 ch2 hi", v, 16'h0000);
    rd(2'd3, 1'b0, v); chk("R1 ch3 lo", v, 16'h0000);
    chk("R1 irq", 16'(irqOut), 16'd0);

    // R5 upper-half layout, unused bits dropped
    wr(2'd2, 1'b1, 16'h6005);
    rd(2'd2, 1'b1, v); chk("R5 ch2 hi", v, 16'h0005);
    wr(2'd3, 1'b1, 16'h1007);
    // R6 lower half leaves upper untouched
    wr(2'd3, 1'b0, 16'h0155);
    rd(2'd3, 1'b0, v); chk("R6 ch3 lo", v, 16'h0155);
    rd(2'd3, 1'b1, v); chk("R6 ch3 hi kept", v, 16'h1007);

    // R2 R3 R4 beam sequence
    foreach (VEC[k]) begin
      adv(VEC[k][14:5]);
      @(negedge clk);
      pend(p);
      chk("R2 pending", 16'(p), 16'(VEC[k][4:1]));
      chk("R3 R4 irq", 16'(irqOut), 16'(VEC[k][0]));
    end

    // R5 acknowledge channels by writing pending 0
    wr(2'd0, 1'b1, 16'h1107);
    wr(2'd1, 1'b1, 16'h1001);
    wr(2'd3, 1'b1, 16'h1007);
    @(negedge clk);
    pend(p); chk("R5 ack pending", 16'(p), 16'b0100);
    chk("R4 masked only irq", 16'(irqOut), 16'd0);

    // R3 registered: pending set by write, irq one clock later
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd3; wrHigh = 1'b1; wrData = 16'h9007;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R3 irq not yet", 16'(irqOut), 16'd0);
    @(negedge clk);
    chk("R3 irq one later", 16'(irqOut), 16'd1);
    // R4 clearing mask drops irq
    wr(2'd3, 1'b1, 16'h8007);
    @(negedge clk);
    chk("R4 mask off irq", 16'(irqOut), 16'd0);

    // R7 clear wins over same-cycle write and match
    @(negedge clk);
    clearAll = 1'b1; wrEn = 1'b1; wrSel = 2'd1; wrHigh = 1'b1; wrData = 16'h9001;
    beamAdv = 1'b1; beamLine = 10'd5;
    @(negedge clk);
    clearAll = 1'b0; wrEn = 1'b0; beamAdv = 1'b0;
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 1'b1, v); chk("R7 hi zero", v, 16'h0000);
      rd(2'(c), 1'b0, v); chk("R7 lo zero", v, 16'h0000);
    end
    @(negedge clk);
    chk("R7 irq", 16'(irqOut), 16'd0);

    // R9 no advance no match
    wr(2'd2, 1'b1, 16'h1009);
    @(negedge clk);
    beamLine = 10'd9;
    repeat (2) @(negedge clk);
    pend(p); chk("R9 no advance", 16'(p), 16'b0000);

    // R8 write beats same-cycle match
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd2; wrHigh = 1'b1; wrData = 16'h1009;
    beamAdv = 1'b1; beamLine = 10'd9;
    @(negedge clk);
    wrEn = 1'b0; beamAdv = 1'b0;
    pend(p); chk("R8 write wins", 16'(p), 16'b0000);
    adv(10'd9);
    pend(p); chk("R2 later match", 16'(p), 16'b0100);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule